// File: doc/BRIEF.md
# Sleep-to-Wake Rate Controller

This block picks the sampling rate and power mode that a sensor core actually runs at. The host programs a main rate register. That register holds a normal-mode rate code, a low-power rate code and a bit that selects low-power operation. The host also programs a separate arming register whose 2-bit field turns an automatic wake function on or off. While the function is off, the effective mode and rate follow the main rate register directly.

When the arming field is set to 11, the core drops into low-power operation at the programmed low-power rate. The controller then waits for an interrupt event from the sensor's detection logic. On the first sample tick after such an event, it switches the effective mode to normal at the normal-mode rate and raises a one-cycle mode-change pulse. The stored main rate register is never rewritten by this switch, so the host always reads back exactly what it wrote. Any write to the arming register clears a wake that has happened and starts over from the configured state.

Top module: `stw_rate_ctrl`

## Requirements
- R1: After reset, both registers read 0, `pwr_mode` is 0 (normal), `rate_code` is 0 and `mode_chg` is 0.
- R2: The arming register at address 1 keeps only write-data bits [1:0]. Read-data bits [7:2] at that address are always 0.
- R3: The main rate register at address 0 reads back the full 8-bit value last written, including after a wake. Its layout is: bits [2:0] normal rate code, bits [5:3] low-power rate code, bit 6 low-power select, bit 7 spare.
- R4: With the arming field at 00, 01 or 10, `pwr_mode` equals bit 6 of the main register. `rate_code` is bits [5:3] when bit 6 is 1 and bits [2:0] otherwise. Interrupt events and ticks have no effect.
- R5: With the arming field at 11 and no wake yet, `pwr_mode` is 1 and `rate_code` is bits [5:3] of the main register, whatever bit 6 holds. A tick with no earlier event changes nothing.
- R6: While armed, an `irq_event` pulse causes a wake at the clock edge of the first `sample_tick` in a later cycle than the event. From then on, `pwr_mode` is 0 and `rate_code` is bits [2:0]. A tick in the same cycle as the event does not wake.
- R7: `mode_chg` is 1 for exactly the one cycle after the waking edge, and 0 at all other times.
- R8: Any write to the arming register cancels a wake and any pending event. The outputs then follow R5 if the new field is 11, or R4 otherwise.
- R9: Writes to addresses 2 and 3 change no register, and reads there return 0.
- R10: After a wake, further events and ticks cause no new `mode_chg` until the arming register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| sample_tick | input | 1 | One-cycle pulse marking a sample period boundary |
| irq_event | input | 1 | One-cycle interrupt event from the sensor logic |
| pwr_mode | output | 1 | Effective mode: 1 low-power, 0 normal |
| rate_code | output | 3 | Effective rate code |
| mode_chg | output | 1 | One-cycle pulse on a wake |

## Verification
A stuck or lost wake flag shows at once on `pwr_mode` and `rate_code`: the block either stays in low-power after a tick that should wake it, or sits in normal mode straight after arming. Both are visible in the cycle after the relevant edge. A pending event that is wrongly kept or dropped shows up at the next tick, which either wakes too early (a same-cycle event) or fails to wake. Corruption of the stored rate register shows on the next read at address 0. The sweep covers every main-register value, so a wrongly mapped rate field cannot go unnoticed.

// File: rtl/stw_pkg.sv
package stw_pkg;
    localparam int REG_W     = 8;
    localparam int RATE_W    = 3;
    localparam int ADDR_W    = 2;
    localparam int ARM_W     = 2;
    localparam logic [ADDR_W-1:0] ADDR_RATE = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ARM  = 2'd1;
    localparam logic [ARM_W-1:0]  ARM_ON    = 2'b11;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_LOWPWR = 1'b1
    } mode_e;

    typedef struct packed {
        logic              spare;
        logic              lp_sel;
        logic [RATE_W-1:0] lp_rate;
        logic [RATE_W-1:0] nrm_rate;
    } rate_reg_t;

    typedef struct packed {
        mode_e             mode;
        logic [RATE_W-1:0] rate;
    } eff_t;

    function automatic eff_t pick_eff(input logic low, input logic [RATE_W-1:0] lpr,
                                      input logic [RATE_W-1:0] nr);
        eff_t e;
        e.mode = low ? MODE_LOWPWR : MODE_NORMAL;
        e.rate = low ? lpr : nr;
        return e;
    endfunction
endpackage

// File: rtl/stw_regs.sv
module stw_regs
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output rate_reg_t         rate_reg,
    output logic [ARM_W-1:0]  arm_fld,
    output logic              arm_wr
);
    localparam int PAD_W = REG_W - ARM_W;

    rate_reg_t        rate_q;
    logic [ARM_W-1:0] arm_q;
    logic             sel_rate, sel_arm;

    assign sel_rate = wr_en && (wr_addr == ADDR_RATE);
    assign sel_arm  = wr_en && (wr_addr == ADDR_ARM);

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            arm_q  <= '0;
        end else begin
            if (sel_rate) rate_q <= rate_reg_t'(wr_data);
            if (sel_arm)  arm_q  <= wr_data[ARM_W-1:0];
        end
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_RATE: rd_data = rate_q;
            ADDR_ARM:  rd_data = {{PAD_W{1'b0}}, arm_q};
            default:   rd_data = '0;
        endcase
    end

    assign rate_reg = rate_q;
    assign arm_fld  = arm_q;
    assign arm_wr   = sel_arm;
endmodule

// File: rtl/stw_wake.sv
module stw_wake (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic arm_wr,
    input  logic irq_event,
    input  logic sample_tick,
    output logic woken,
    output logic mode_chg
);
    logic pend_q, woke_q, chg_q;
    logic wake_now;

    assign wake_now = armed && sample_tick && pend_q && !woke_q;

    always_ff @(posedge clk) begin
        if (rst || arm_wr || !armed) begin
            pend_q <= 1'b0;
            woke_q <= 1'b0;
            chg_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q || irq_event) && !wake_now && !woke_q;
            woke_q <= woke_q || wake_now;
            chg_q  <= wake_now;
        end
    end

    assign woken    = woke_q;
    assign mode_chg = chg_q;
endmodule

// File: rtl/stw_rate_sel.sv
module stw_rate_sel
    import stw_pkg::*;
(
    input  logic              armed,
    input  logic              woken,
    input  logic              lp_sel,
    input  logic [RATE_W-1:0] lp_rate,
    input  logic [RATE_W-1:0] nrm_rate,
    output eff_t              eff
);
    logic want_low;

    always_comb begin
        if (armed) want_low = !woken;
        else       want_low = lp_sel;
        eff = pick_eff(want_low, lp_rate, nrm_rate);
    end
endmodule

// File: rtl/stw_rate_ctrl.sv
module stw_rate_ctrl
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              sample_tick,
    input  logic              irq_event,
    output logic              pwr_mode,
    output logic [RATE_W-1:0] rate_code,
    output logic              mode_chg
);
    rate_reg_t        rate_w;
    logic [ARM_W-1:0] arm_w;
    logic             arm_wr_w, armed_w, woken_w;
    eff_t             eff_w;

    stw_regs regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rate_reg(rate_w), .arm_fld(arm_w),
        .arm_wr(arm_wr_w)
    );

    assign armed_w = (arm_w == ARM_ON);

    stw_wake wake_i (
        .clk(clk), .rst(rst), .armed(armed_w), .arm_wr(arm_wr_w),
        .irq_event(irq_event), .sample_tick(sample_tick),
        .woken(woken_w), .mode_chg(mode_chg)
    );

    stw_rate_sel sel_i (
        .armed(armed_w), .woken(woken_w), .lp_sel(rate_w.lp_sel),
        .lp_rate(rate_w.lp_rate), .nrm_rate(rate_w.nrm_rate), .eff(eff_w)
    );

    assign pwr_mode  = eff_w.mode;
    assign rate_code = eff_w.rate;
endmodule

// File: rtl/stw_rate_ctrl_chk.sv
module stw_rate_ctrl_chk
    import stw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [REG_W-1:0]  rd_data,
    input logic              pwr_mode,
    input logic              mode_chg,
    input rate_reg_t         rate_w,
    input logic [ARM_W-1:0]  arm_w
);
    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !mode_chg);

    // R6
    wake_switch_chk: assert property (@(posedge clk) disable iff (rst)
        mode_chg |-> (pwr_mode == 1'b0) && ($past(pwr_mode) == 1'b1));

    // R3
    rate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == ADDR_RATE) |=> $stable(rate_w));

    // R4
    disabled_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_w != ARM_ON) |-> (pwr_mode == rate_w.lp_sel) && !mode_chg);

    // R2
    arm_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_ARM) |-> (rd_data[REG_W-1:ARM_W] == '0));

    // R10
    no_rewake_chk: assert property (@(posedge clk) disable iff (rst)
        ((arm_w == ARM_ON) && !pwr_mode && !(wr_en && wr_addr == ADDR_ARM)) |=> !mode_chg);
endmodule

bind stw_rate_ctrl stw_rate_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwr_mode(pwr_mode), .mode_chg(mode_chg),
    .rate_w(rate_w), .arm_w(arm_w)
);

// File: tb/stw_rate_ctrl_tb.sv
module stw_rate_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       sample_tick = 1'b0;
    logic       irq_event = 1'b0;
    logic       pwr_mode;
    logic [2:0] rate_code;
    logic       mode_chg;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stw_rate_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sample_tick(sample_tick),
        .irq_event(irq_event), .pwr_mode(pwr_mode), .rate_code(rate_code),
        .mode_chg(mode_chg)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic irq, input logic tick);
        irq_event = irq; sample_tick = tick;
        @(negedge clk);
        irq_event = 1'b0; sample_tick = 1'b0;
    endtask

    function automatic int rd(input logic [1:0] a);
        rd_addr = a;
        return 0;
    endfunction

    task automatic read_chk(input string req, input logic [1:0] a, input int exp);
        rd_addr = a;
        #1;
        check(req, int'(rd_data), exp);
    endtask

    task automatic outs_chk(input string req, input int pm, input int rc, input int chg);
        check({req, " pwr_mode"}, int'(pwr_mode), pm);
        check({req, " rate_code"}, int'(rate_code), rc);
        check({req, " mode_chg"}, int'(mode_chg), chg);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lp, lpr, nr, ig;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        outs_chk("R1", 0, 0, 0);
        read_chk("R1 rate reg", 2'd0, 0);
        read_chk("R1 arm reg", 2'd1, 0);

        // R4 disabled codes, every main-register value
        for (int t = 0; t < 3; t++) begin
            wr(2'd1, 8'(t));
            for (int c = 0; c < 256; c++) begin
                wr(2'd0, 8'(c));
                lp = (c >> 6) & 1; lpr = (c >> 3) & 7; nr = c & 7;
                if (c % 16 == 3) begin
                    pulse(1'b1, 1'b0);
                    pulse(1'b0, 1'b1);
                end
                outs_chk("R4", lp, lp ? lpr : nr, 0);
                read_chk("R3 readback", 2'd0, c);
                read_chk("R2 arm readback", 2'd1, t);
            end
        end

        // R2 upper bits dropped
        wr(2'd1, 8'hFE);
        read_chk("R2 pad", 2'd1, 2);
        wr(2'd1, 8'hFF);
        read_chk("R2 pad", 2'd1, 3);

        // R5..R10 armed sweep
        for (int c = 0; c < 256; c++) begin
            lpr = (c >> 3) & 7; nr = c & 7; lp = (c >> 6) & 1;
            wr(2'd0, 8'(c));
            wr(2'd1, 8'h03);
            outs_chk("R5 armed", 1, lpr, 0);
            pulse(1'b0, 1'b1);
            outs_chk("R5 lone tick", 1, lpr, 0);
            pulse(1'b1, 1'b1);
            outs_chk("R6 same-cycle tick", 1, lpr, 0);
            pulse(1'b0, 1'b1);
            outs_chk("R6 wake", 0, nr, 1);
            read_chk("R3 after wake", 2'd0, c);
            @(negedge clk);
            outs_chk("R7 pulse end", 0, nr, 0);
            pulse(1'b1, 1'b0);
            pulse(1'b0, 1'b1);
            outs_chk("R10 no rewake", 0, nr, 0);
            wr(2'd1, 8'h03);
            outs_chk("R8 rearm", 1, lpr, 0);
            if (c % 2 == 0) begin
                pulse(1'b1, 1'b0);
                wr(2'd1, 8'h03);
                pulse(1'b0, 1'b1);
                outs_chk("R8 pending cleared", 1, lpr, 0);
            end
            wr(2'd1, 8'h00);
            outs_chk("R8 disarm", lp, lp ? lpr : nr, 0);
        end

        // R9 unmapped addresses
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'h03);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h00);
        read_chk("R9 rate kept", 2'd0, 8'h5A);
        read_chk("R9 arm kept", 2'd1, 3);
        read_chk("R9 addr2 reads 0", 2'd2, 0);
        read_chk("R9 addr3 reads 0", 2'd3, 0);
        ig = rd(2'd0);
        outs_chk("R9 outputs", 1, 3, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule